// File: doc/BRIEF.md
# Load-Use Stall Controller

This combinational unit sits beside the decode stage of an in-order five-stage pipeline. It looks at the instruction now in execute and at the instruction being decoded. It raises a stall when the execute instruction is a memory load and the register that load will write is one of the two registers the decode instruction reads. In that case the loaded value is not yet available, and forwarding cannot supply it in time.

A stall does three things in the same cycle. The fetch address register holds its value. The fetch/decode pipeline register holds its value. The control fields written into the decode/execute register are cleared, so that slot moves down the pipe as a no-op. The instruction word itself is left alone, because it has already been decoded. On the next cycle the load has moved on and a bubble sits in execute, so the stall condition drops by itself. Every load-use pair therefore costs exactly one cycle, and the forwarding path handles the dependency from then on.

Top module: `lu_hazard_unit`

## Requirements
- R1: A stall is raised when `ex_mem_rd` is 1 and `ex_dst_reg` equals `id_src_a`.
- R2: A stall is raised when `ex_mem_rd` is 1 and `ex_dst_reg` equals `id_src_b`.
- R3: When `ex_mem_rd` is 0, no stall is raised, even if the register numbers match.
- R4: When `ex_mem_rd` is 1 but `ex_dst_reg` matches neither source, no stall is raised. Register number 0 gets no special treatment.
- R5: During a stall, `pc_wr_en` is 0.
- R6: During a stall, `ifid_wr_en` is 0.
- R7: During a stall, `idex_ctl_clear` is 1. This zeroes the control fields going into decode/execute and leaves the instruction bits as they are.
- R8: Without a stall, `pc_wr_en` and `ifid_wr_en` are 1 and `idex_ctl_clear` is 0.
- R9: In a running pipeline, each load followed directly by a dependent instruction produces exactly one bubble. The dependent instruction then enters execute on the following cycle.
- R10: When both sources equal the load destination, the result is still a single ordinary stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_rd | input | 1 | Execute-stage instruction reads data memory (it is a load) |
| ex_dst_reg | input | REG_W | Register the execute-stage load writes |
| id_src_a | input | REG_W | First source register of the decode-stage instruction |
| id_src_b | input | REG_W | Second source register of the decode-stage instruction |
| pc_wr_en | output | 1 | Fetch address register update enable |
| ifid_wr_en | output | 1 | Fetch/decode register update enable |
| idex_ctl_clear | output | 1 | Clear control fields loaded into decode/execute |

## Verification
All three outputs are combinational, so each one is due in the same cycle its inputs are applied. The table checks change the inputs away from the clock edge and sample after a short settle delay. The pipeline test is different. It wraps the unit in a registered model of the fetch address, fetch/decode and decode/execute registers. The effect of a stall appears one edge later, as a bubble in execute, and the dependent instruction appears there on the edge after that. So the execute-stage sequence is captured once per cycle at the falling edge and compared slot by slot against the expected order.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

  // Default register index width (32 architectural registers).
  localparam int unsigned REG_W_DEF = 5;
  // Number of decode-stage source operands compared against the load target.
  localparam int unsigned NUM_SRC   = 2;

  typedef struct packed {
    logic pc_we;      // fetch address may advance
    logic ifid_we;    // fetch/decode register may load
    logic ctl_clear;  // zero the control slice into decode/execute
  } stall_ctl_t;

endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned SRC_CNT = 2
) (
  input  logic [REG_W-1:0]               dst_reg,
  input  logic [SRC_CNT-1:0][REG_W-1:0]  src_regs,
  output logic [SRC_CNT-1:0]             hit_vec
);

  // One equality comparator per source operand.
  for (genvar g = 0; g < SRC_CNT; g++) begin : g_cmp
    assign hit_vec[g] = (src_regs[g] == dst_reg);
  end

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
  import lu_hazard_pkg::*;
#(
  parameter int unsigned SRC_CNT = 2
) (
  input  logic               load_in_ex,
  input  logic [SRC_CNT-1:0] hit_vec,
  output stall_ctl_t         ctl
);

  logic stall_req;

  always_comb begin
    stall_req     = load_in_ex && (|hit_vec);
    ctl.pc_we     = ~stall_req;
    ctl.ifid_we   = ~stall_req;
    ctl.ctl_clear = stall_req;
  end

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_hazard_pkg::*;
#(
  parameter int unsigned REG_W = REG_W_DEF
) (
  input  logic             ex_mem_rd,
  input  logic [REG_W-1:0] ex_dst_reg,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  output logic             pc_wr_en,
  output logic             ifid_wr_en,
  output logic             idex_ctl_clear
);

  localparam int unsigned SRC_CNT = NUM_SRC;

  logic [SRC_CNT-1:0][REG_W-1:0] src_bus;
  logic [SRC_CNT-1:0]            src_hit;
  stall_ctl_t                    ctl_s;

  assign src_bus[0] = id_src_a;
  assign src_bus[1] = id_src_b;

  lu_src_match #(
    .REG_W   (REG_W),
    .SRC_CNT (SRC_CNT)
  ) match_i (
    .dst_reg  (ex_dst_reg),
    .src_regs (src_bus),
    .hit_vec  (src_hit)
  );

  lu_stall_ctrl #(
    .SRC_CNT (SRC_CNT)
  ) ctrl_i (
    .load_in_ex (ex_mem_rd),
    .hit_vec    (src_hit),
    .ctl        (ctl_s)
  );

  assign pc_wr_en       = ctl_s.pc_we;
  assign ifid_wr_en     = ctl_s.ifid_we;
  assign idex_ctl_clear = ctl_s.ctl_clear;

  // Port-level consistency between the comparator and the control stage.
  always_comb begin
    AST_CLEAR_NEEDS_LOAD: assert (!idex_ctl_clear || ex_mem_rd);        // R3
    AST_CLEAR_NEEDS_MATCH: assert (!idex_ctl_clear ||
      (ex_dst_reg == id_src_a) || (ex_dst_reg == id_src_b));            // R4
    AST_HIT_A_STALLS: assert (!(ex_mem_rd && ex_dst_reg == id_src_a) ||
      idex_ctl_clear);                                                   // R1
    AST_HIT_B_STALLS: assert (!(ex_mem_rd && ex_dst_reg == id_src_b) ||
      idex_ctl_clear);                                                   // R2
    AST_PC_FROZEN: assert (pc_wr_en != idex_ctl_clear);                 // R5
    AST_IFID_FROZEN: assert (ifid_wr_en == pc_wr_en);                   // R6
  end

endmodule

// File: tb/lu_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module lu_hazard_unit_tb_top;

  localparam int unsigned RW = 5;
  localparam logic [3:0] NOP_IDX = 4'd14;
  localparam logic [3:0] BUB_IDX = 4'd15;

  logic clk;
  logic rst_n;
  int   n_run;
  int   n_fail;

  logic          ex_mem_rd;
  logic [RW-1:0] ex_dst_reg, id_src_a, id_src_b;
  logic          pc_wr_en, ifid_wr_en, idex_ctl_clear;
  logic          use_model;

  // Table-driven inputs and model-driven inputs share the DUT through a mux.
  logic          t_ld;
  logic [RW-1:0] t_dst, t_a, t_b;

  lu_hazard_unit #(.REG_W(RW)) dut_i (
    .ex_mem_rd      (ex_mem_rd),
    .ex_dst_reg     (ex_dst_reg),
    .id_src_a       (id_src_a),
    .id_src_b       (id_src_b),
    .pc_wr_en       (pc_wr_en),
    .ifid_wr_en     (ifid_wr_en),
    .idex_ctl_clear (idex_ctl_clear)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- pipeline model ----------------
  typedef struct packed {
    logic [3:0]    idx;
    logic          ld;
    logic [RW-1:0] dst;
    logic [RW-1:0] a;
    logic [RW-1:0] b;
  } instr_t;

  function automatic instr_t imem(input logic [3:0] pc);
    instr_t r;
    r = '{idx: NOP_IDX, ld: 1'b0, dst: 5'd0, a: 5'd0, b: 5'd0};
    case (pc)
      4'd0: r = '{idx: 4'd0, ld: 1'b1, dst: 5'd2,  a: 5'd1,  b: 5'd0};  // load r2
      4'd1: r = '{idx: 4'd1, ld: 1'b0, dst: 5'd4,  a: 5'd2,  b: 5'd5};  // uses r2 (first src)
      4'd2: r = '{idx: 4'd2, ld: 1'b0, dst: 5'd8,  a: 5'd6,  b: 5'd7};
      4'd3: r = '{idx: 4'd3, ld: 1'b1, dst: 5'd9,  a: 5'd3,  b: 5'd0};  // load r9
      4'd4: r = '{idx: 4'd4, ld: 1'b0, dst: 5'd10, a: 5'd11, b: 5'd9};  // uses r9 (second src)
      4'd5: r = '{idx: 4'd5, ld: 1'b0, dst: 5'd12, a: 5'd13, b: 5'd14};
      default: ;
    endcase
    return r;
  endfunction

  logic [3:0] pc_q, pc_d;
  instr_t     ifid_q, ifid_d, idex_q, idex_d;
  instr_t     nop_i;

  assign nop_i = '{idx: NOP_IDX, ld: 1'b0, dst: 5'd0, a: 5'd0, b: 5'd0};

  always_comb begin
    pc_d   = pc_wr_en   ? pc_q + 4'd1 : pc_q;
    ifid_d = ifid_wr_en ? imem(pc_q)  : ifid_q;
    idex_d = ifid_q;
    if (idex_ctl_clear) begin
      idex_d.ld  = 1'b0;        // control zeroed
      idex_d.idx = BUB_IDX;     // tag slot as bubble for observation
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= 4'd0;
      ifid_q <= nop_i;
      idex_q <= nop_i;
    end else begin
      pc_q   <= pc_d;
      ifid_q <= ifid_d;
      idex_q <= idex_d;
    end
  end

  always_comb begin
    if (use_model) begin
      ex_mem_rd  = idex_q.ld;
      ex_dst_reg = idex_q.dst;
      id_src_a   = ifid_q.a;
      id_src_b   = ifid_q.b;
    end else begin
      ex_mem_rd  = t_ld;
      ex_dst_reg = t_dst;
      id_src_a   = t_a;
      id_src_b   = t_b;
    end
  end

  // ---------------- stimulus table ----------------
  // {req[20:17], ld[16], dst[15:11], a[10:6], b[5:1], stall[0]}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1,  1'b1, 5'd2,  5'd2,  5'd7,  1'b1},  // R1 first source hit
    {4'd2,  1'b1, 5'd9,  5'd3,  5'd9,  1'b1},  // R2 second source hit
    {4'd3,  1'b0, 5'd5,  5'd5,  5'd5,  1'b0},  // R3 match but not a load
    {4'd4,  1'b1, 5'd6,  5'd7,  5'd8,  1'b0},  // R4 load, no match
    {4'd10, 1'b1, 5'd31, 5'd31, 5'd31, 1'b1},  // R10 both sources hit
    {4'd1,  1'b1, 5'd0,  5'd0,  5'd4,  1'b1},  // R1 register zero still stalls
    {4'd3,  1'b0, 5'd0,  5'd0,  5'd0,  1'b0},  // R3 all zero, no load
    {4'd4,  1'b1, 5'd12, 5'd13, 5'd11, 1'b0},  // R4 near miss
    {4'd2,  1'b1, 5'd17, 5'd1,  5'd17, 1'b1}   // R2 second source hit
  };

  localparam logic [3:0] EXP_EX [8] = '{
    4'd0, BUB_IDX, 4'd1, 4'd2, 4'd3, BUB_IDX, 4'd4, 4'd5
  };

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    n_run = 0; n_fail = 0;
    use_model = 1'b0;
    t_ld = 1'b0; t_dst = '0; t_a = '0; t_b = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #0.5;
    // Quiescent state: R8
    check("R8 pc_wr_en idle", {31'd0, pc_wr_en}, 32'd1);
    check("R8 ifid_wr_en idle", {31'd0, ifid_wr_en}, 32'd1);
    check("R8 clear idle", {31'd0, idex_ctl_clear}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      logic        st;
      string       rq;
      v = VEC[i];
      @(negedge clk);
      t_ld = v[16]; t_dst = v[15:11]; t_a = v[10:6]; t_b = v[5:1];
      st = v[0];
      #0.5;
      rq = $sformatf("R%0d vec%0d", v[20:17], i);
      check({rq, " clear"}, {31'd0, idex_ctl_clear}, {31'd0, st});
      if (st) begin
        check({rq, " R5 pc held"},  {31'd0, pc_wr_en},   32'd0);
        check({rq, " R6 ifid held"}, {31'd0, ifid_wr_en}, 32'd0);
        check({rq, " R7 bubble"},    {31'd0, idex_ctl_clear}, 32'd1);
      end else begin
        check({rq, " R8 pc runs"},   {31'd0, pc_wr_en},   32'd1);
        check({rq, " R8 ifid runs"}, {31'd0, ifid_wr_en}, 32'd1);
      end
    end

    // ---------------- pipeline run: R9 ----------------
    @(negedge clk);
    rst_n = 1'b0;
    use_model = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int guard, stalls, prev, back2back;
      guard = 0;
      while (idex_q.idx != 4'd0 && guard < 20) begin
        @(negedge clk);
        guard++;
      end
      check("R9 load reaches execute", {28'd0, idex_q.idx}, 32'd0);
      stalls = 0; prev = 0; back2back = 0;
      for (int k = 0; k < 8; k++) begin
        check($sformatf("R9 execute slot %0d", k), {28'd0, idex_q.idx}, {28'd0, EXP_EX[k]});
        if (idex_ctl_clear) begin
          stalls++;
          if (prev != 0) back2back++;
          prev = 1;
        end else prev = 0;
        @(negedge clk);
      end
      check("R9 bubble count", stalls, 2);
      check("R9 no back-to-back stall", back2back, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule